// File: doc/BRIEF.md
# Greedy Cache Configuration Tuner

This block drives a search for the cache setting that uses the least energy. The setting has three knobs, and each knob has three values: capacity (2, 4 or 8 KB), line length (16, 32 or 64 bytes) and ways (1, 2 or 4). The block does not walk through all 27 combinations. It tunes one knob at a time, in a fixed order: capacity, then line length, then ways. It raises the current knob while an external energy comparison reports an improvement. When the comparison reports no improvement, it returns the knob to its last good value and moves on to the next knob.

For each trial the block presents the trial setting and pulses `calcStart`. It then waits for `calcDone`, and on that cycle it reads the verdict on `tuneAgain`. Several cores can share the block. Their sessions run one after another, and `coreSel` tells the statistics multiplexers which core is active. `busy` stays high for the whole session. Dropping `start` abandons the session.

Top module: `cacheTuneCtl`

## Requirements
- R1: After reset, and while idle, `busy`=0, `calcStart`=0 and `paramSel`=0. After reset `cfgBits`=0 and `coreSel`=0. The block stays idle while `start`=0.
- R2: On the clock edge that sees `start`=1 while idle, the block enters the first trial. `busy`=1, `calcStart`=1, `cfgBits`=0, `paramSel`=1 (capacity) and `coreSel`=0.
- R3: `calcStart` is high for exactly one cycle per trial. While the block waits for `calcDone`, `cfgBits` and `paramSel` hold. A `calcDone` that arrives in the `calcStart` cycle is ignored.
- R4: On `calcDone`=1 with `tuneAgain`=1, if the field of the knob being tuned is below 2, that field increases by one and a new trial (`calcStart`=1) begins on the next cycle.
- R5: On `calcDone`=1 with `tuneAgain`=0, the current field drops by one if it is above 0. The next knob then becomes active in the order capacity (`paramSel`=1), line (2), ways (3), and its first trial uses index 1.
- R6: On `calcDone`=1 with `tuneAgain`=1 and the current field already at 2, the field stays at 2 and the block advances as in R5.
- R7: When the ways knob finishes, the block behaves as follows. If it is not on the last core, `coreSel` increments, `cfgBits` returns to 0, `paramSel`=1 and a trial starts. On the last core it goes idle (`busy`=0, `paramSel`=0) and keeps the final `cfgBits` and `coreSel`.
- R8: `start`=0 seen in any busy cycle returns the block to idle on the next cycle, with `paramSel`=0 and `cfgBits` unchanged.
- R9: `cfgBits` packs three 2-bit indices: capacity in [1:0], line in [3:2], ways in [5:4]. For capacity, index i means 2<<i KB. For line, it means 16<<i bytes. For ways, it means 1<<i. The index 3 never appears.
- R10: `busy` stays high with no gap from the first trial until the session ends or is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request and keep a tuning session running |
| calcDone | input | 1 | Energy result for the current trial is ready |
| tuneAgain | input | 1 | Verdict with calcDone: 1 = trial improved energy |
| cfgBits | output | 6 | Trial or chosen setting {ways, line, capacity} |
| calcStart | output | 1 | One-cycle request to evaluate the presented setting |
| busy | output | 1 | Session in progress |
| coreSel | output | CORE_W | Index of the core being tuned |
| paramSel | output | 2 | Knob being tuned: 0 none, 1 capacity, 2 line, 3 ways |

## Verification
Some verdicts do two things on one edge. The most important is a "no improvement" verdict, which lowers one field and raises the next field on the same edge. This happens at every knob boundary, and at the end of a core it also coincides with the core switch. The bench sends verdicts of both polarities at index 0, in the middle of the range and at index 2, then compares the whole setting with a behavioural model on every cycle. It also checks hand-computed settings at each boundary. A `calcDone` sent in the same cycle as `calcStart`, and an abort sent in a `calcStart` cycle, check that one event does not take over the other.

// File: rtl/cacheTunePkg.sv
package cacheTunePkg;
  localparam int NUM_KNOBS = 3;
  localparam int IDX_W     = 2;
  localparam int MAX_IDX   = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_APPLY = 2'd1,
    ST_CALC  = 2'd2
  } tuneState_t;

  typedef struct packed {
    logic loadBase;
    logic advCore;
    logic stepUp;
    logic revert;
    logic advParam;
    logic clrParam;
  } tuneStrobe_t;
endpackage

// File: rtl/cacheTuneCtrl.sv
module cacheTuneCtrl
  import cacheTunePkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        calcDone,
  input  logic        tuneAgain,
  input  logic        atMax,
  input  logic        lastParam,
  input  logic        lastCore,
  output tuneStrobe_t strobe,
  output logic        calcStart,
  output logic        busy
);
  tuneState_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    strobe   = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.loadBase = 1'b1;
          stateNxt        = ST_APPLY;
        end
      end
      ST_APPLY: begin
        if (!start) begin
          strobe.clrParam = 1'b1;
          stateNxt        = ST_IDLE;
        end else begin
          stateNxt = ST_CALC;
        end
      end
      ST_CALC: begin
        if (!start) begin
          strobe.clrParam = 1'b1;
          stateNxt        = ST_IDLE;
        end else if (calcDone) begin
          if (tuneAgain && !atMax) begin
            strobe.stepUp = 1'b1;
            stateNxt      = ST_APPLY;
          end else begin
            strobe.revert = !tuneAgain;
            if (!lastParam) begin
              strobe.advParam = 1'b1;
              stateNxt        = ST_APPLY;
            end else if (!lastCore) begin
              strobe.advCore = 1'b1;
              stateNxt       = ST_APPLY;
            end else begin
              strobe.clrParam = 1'b1;
              stateNxt        = ST_IDLE;
            end
          end
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign calcStart = (state == ST_APPLY);
  assign busy      = (state != ST_IDLE);
endmodule

// File: rtl/cacheTuneData.sv
module cacheTuneData
  import cacheTunePkg::*;
#(
  parameter int NUM_CORES = 4,
  localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  tuneStrobe_t                 strobe,
  output logic                        atMax,
  output logic                        lastParam,
  output logic                        lastCore,
  output logic [NUM_KNOBS*IDX_W-1:0]  cfgBits,
  output logic [CORE_W-1:0]           coreSel,
  output logic [1:0]                  paramSel
);
  localparam logic [CORE_W-1:0] LAST_CORE = CORE_W'(NUM_CORES - 1);
  localparam logic [IDX_W-1:0]  TOP_IDX   = IDX_W'(MAX_IDX);

  logic [1:0]       param;
  logic [CORE_W-1:0] core;
  logic [IDX_W-1:0] fld [NUM_KNOBS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  param <= 2'd0;
    else if (strobe.loadBase || strobe.advCore) param <= 2'd1;
    else if (strobe.advParam)                   param <= param + 2'd1;
    else if (strobe.clrParam)                   param <= 2'd0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 core <= '0;
    else if (strobe.loadBase)  core <= '0;
    else if (strobe.advCore)   core <= core + 1'b1;
  end

  for (genvar g = 0; g < NUM_KNOBS; g++) begin : gKnob
    localparam logic [1:0] MY_CODE = 2'(g + 1);
    localparam logic [1:0] PREV_CODE = 2'(g);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        fld[g] <= '0;
      else if (strobe.loadBase || strobe.advCore)
        fld[g] <= '0;
      else if (strobe.stepUp && param == MY_CODE)
        fld[g] <= fld[g] + 1'b1;
      else if (strobe.revert && param == MY_CODE && fld[g] != '0)
        fld[g] <= fld[g] - 1'b1;
      else if (strobe.advParam && param == PREV_CODE)
        fld[g] <= IDX_W'(1);
    end
    assign cfgBits[g*IDX_W +: IDX_W] = fld[g];
  end

  always_comb begin
    atMax = 1'b0;
    for (int k = 0; k < NUM_KNOBS; k++)
      if (param == 2'(k + 1)) atMax = (fld[k] == TOP_IDX);
  end

  assign lastParam = (param == 2'(NUM_KNOBS));
  assign lastCore  = (core == LAST_CORE);
  assign coreSel   = core;
  assign paramSel  = param;
endmodule

// File: rtl/cacheTuneCtl.sv
module cacheTuneCtl
  import cacheTunePkg::*;
#(
  parameter int NUM_CORES = 4,
  localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              calcDone,
  input  logic              tuneAgain,
  output logic [5:0]        cfgBits,
  output logic              calcStart,
  output logic              busy,
  output logic [CORE_W-1:0] coreSel,
  output logic [1:0]        paramSel
);
  tuneStrobe_t strobe;
  logic atMax, lastParam, lastCore;

  cacheTuneCtrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .calcDone(calcDone),
    .tuneAgain(tuneAgain), .atMax(atMax), .lastParam(lastParam),
    .lastCore(lastCore), .strobe(strobe), .calcStart(calcStart), .busy(busy)
  );

  cacheTuneData #(.NUM_CORES(NUM_CORES)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .atMax(atMax),
    .lastParam(lastParam), .lastCore(lastCore), .cfgBits(cfgBits),
    .coreSel(coreSel), .paramSel(paramSel)
  );
endmodule

// File: rtl/cacheTuneCtlChk.sv
module cacheTuneCtlChk #(
  parameter int CORE_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              calcDone,
  input logic              tuneAgain,
  input logic [5:0]        cfgBits,
  input logic              calcStart,
  input logic              busy,
  input logic [CORE_W-1:0] coreSel,
  input logic [1:0]        paramSel
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!calcStart && paramSel == 2'd0)); // R1
  AST_START_BASE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> (busy && calcStart && cfgBits == 6'd0 && paramSel == 2'd1 && coreSel == '0)); // R2
  AST_CALC_ONE: assert property (@(posedge clk) disable iff (!rstN)
    calcStart |=> !calcStart); // R3
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !calcStart && !calcDone) |=> ($stable(cfgBits) && $stable(paramSel) && !calcStart)); // R3
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !calcStart && calcDone && tuneAgain && paramSel == 2'd1 && cfgBits[1:0] != 2'd2)
    |=> (cfgBits[1:0] == $past(cfgBits[1:0]) + 2'd1 && calcStart)); // R4
  AST_PARAM_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !calcStart && calcDone && !tuneAgain && paramSel != 2'd3)
    |=> (paramSel == $past(paramSel) + 2'd1)); // R5
  AST_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !start) |=> (!busy && $stable(cfgBits))); // R8
  AST_FIELD_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (cfgBits[1:0] != 2'd3 && cfgBits[3:2] != 2'd3 && cfgBits[5:4] != 2'd3)); // R9
endmodule

bind cacheTuneCtl cacheTuneCtlChk #(.CORE_W(CORE_W)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .calcDone(calcDone),
  .tuneAgain(tuneAgain), .cfgBits(cfgBits), .calcStart(calcStart),
  .busy(busy), .coreSel(coreSel), .paramSel(paramSel)
);

// File: tb/cacheTuneCtl_test.sv
module cacheTuneCtl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int CW = 2;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, calcDone = 1'b0, tuneAgain = 1'b0;
  logic [5:0] cfgBits;
  logic calcStart, busy;
  logic [CW-1:0] coreSel;
  logic [1:0] paramSel;

  int nTests = 0, nFail = 0;
  bit running = 1'b0;

  // behavioural reference state
  int mSt = 0, mPrm = 0, mCore = 0;
  int mF[3] = '{0, 0, 0};

  always #(CLK_PERIOD/2) clk = ~clk;

  cacheTuneCtl #(.NUM_CORES(NC)) uut (
    .clk(clk), .rstN(rstN), .start(start), .calcDone(calcDone),
    .tuneAgain(tuneAgain), .cfgBits(cfgBits), .calcStart(calcStart),
    .busy(busy), .coreSel(coreSel), .paramSel(paramSel)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mSt = 0; mPrm = 0; mCore = 0; mF = '{0, 0, 0};
    end else begin
      case (mSt)
        0: if (start) begin mSt = 1; mF = '{0, 0, 0}; mPrm = 1; mCore = 0; end
        1: if (!start) begin mSt = 0; mPrm = 0; end else mSt = 2;
        default: begin
          if (!start) begin mSt = 0; mPrm = 0; end
          else if (calcDone) begin
            if (tuneAgain && mF[mPrm-1] < 2) begin
              mF[mPrm-1] = mF[mPrm-1] + 1; mSt = 1;
            end else begin
              if (!tuneAgain && mF[mPrm-1] > 0) mF[mPrm-1] = mF[mPrm-1] - 1;
              if (mPrm < 3) begin mPrm = mPrm + 1; mF[mPrm-1] = 1; mSt = 1; end
              else if (mCore < NC-1) begin mCore = mCore + 1; mPrm = 1; mF = '{0, 0, 0}; mSt = 1; end
              else begin mPrm = 0; mSt = 0; end
            end
          end
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rstN && running) begin
      chk("R10 busy", int'(busy), int'(mSt != 0));
      chk("R3 calcStart", int'(calcStart), int'(mSt == 1));
      chk("R4 cfgBits", int'(cfgBits), mF[2]*16 + mF[1]*4 + mF[0]);
      chk("R5 paramSel", int'(paramSel), mPrm);
      chk("R7 coreSel", int'(coreSel), mCore);
    end
  end

  task automatic answer(input int lat, input bit ta);
    for (int g = 0; g < 50 && calcStart !== 1'b1; g++) @(negedge clk);
    repeat (lat) @(negedge clk);
    calcDone = 1'b1; tuneAgain = ta;
    @(negedge clk);
    calcDone = 1'b0; tuneAgain = 1'b0;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(negedge clk);
    nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    running = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset and idle
    chk("R1 busy", int'(busy), 0);
    chk("R1 cfgBits", int'(cfgBits), 0);
    chk("R1 paramSel", int'(paramSel), 0);
    chk("R1 coreSel", int'(coreSel), 0);

    start = 1'b1;
    @(negedge clk);
    // R2: first trial at base setting
    chk("R2 calcStart", int'(calcStart), 1);
    chk("R2 cfgBits", int'(cfgBits), 0);
    chk("R2 paramSel", int'(paramSel), 1);

    // R3: calcDone in the calcStart cycle is ignored
    calcDone = 1'b1; tuneAgain = 1'b1;
    @(negedge clk);
    calcDone = 1'b0; tuneAgain = 1'b0;
    chk("R3 spurious calcStart", int'(calcStart), 0);
    chk("R3 spurious cfgBits", int'(cfgBits), 0);
    chk("R3 spurious busy", int'(busy), 1);

    answer(1, 1'b1);
    chk("R4 size step", int'(cfgBits), 6'b00_00_01);
    answer(2, 1'b1);
    answer(1, 1'b1);
    // R6: at max, kept, line starts at 1
    chk("R6 cfgBits", int'(cfgBits), 6'b00_01_10);
    chk("R6 paramSel", int'(paramSel), 2);
    answer(1, 1'b0);
    // R5: line reverts to 0, ways starts at 1
    chk("R5 cfgBits", int'(cfgBits), 6'b01_00_10);
    chk("R5 paramSel", int'(paramSel), 3);
    answer(1, 1'b1);
    answer(3, 1'b0);
    // R7: next core from base
    chk("R7 coreSel", int'(coreSel), 1);
    chk("R7 cfgBits", int'(cfgBits), 0);
    answer(1, 1'b1);
    // R8: abort during a calcStart cycle
    start = 1'b0;
    @(negedge clk);
    chk("R8 busy", int'(busy), 0);
    chk("R8 paramSel", int'(paramSel), 0);
    chk("R8 cfgBits", int'(cfgBits), 6'b00_00_01);
    repeat (2) @(negedge clk);
    chk("R1 stays idle", int'(busy), 0);

    start = 1'b1;
    @(negedge clk);
    chk("R2 restart cfgBits", int'(cfgBits), 0);
    chk("R2 restart coreSel", int'(coreSel), 0);
    chk("R2 restart calcStart", int'(calcStart), 1);

    for (int c = 0; c < NC-1; c++) begin
      answer(1 + c % 3, 1'b1);
      answer(2, 1'b0);
      answer(1, 1'b0);
      answer(1, 1'b1);
      answer(2, 1'b0);
    end
    chk("R7 last core", int'(coreSel), NC-1);
    answer(1, 1'b0);
    chk("R5 keep index 0", int'(cfgBits), 6'b00_01_00);
    answer(1, 1'b1);
    answer(2, 1'b1);
    chk("R6 line kept", int'(cfgBits), 6'b01_10_00);
    answer(1, 1'b0);
    // R7: session end, idle, final setting kept
    chk("R7 busy end", int'(busy), 0);
    chk("R7 paramSel end", int'(paramSel), 0);
    start = 1'b0;
    // R9: decode of final setting
    chk("R9 size KB", 2 << cfgBits[1:0], 2);
    chk("R9 line bytes", 16 << cfgBits[3:2], 64);
    chk("R9 ways", 1 << cfgBits[5:4], 1);
    repeat (3) @(negedge clk);
    chk("R7 final coreSel", int'(coreSel), NC-1);
    chk("R8 idle holds cfgBits", int'(cfgBits), 6'b00_10_00);
    summary();
  end
endmodule